// File: doc/BRIEF.md
# Supply Monitor Reset Controller

This block is the digital reset sequencer that sits next to a supply-voltage comparator. It receives a power-on pulse and the outputs of two comparators, one for a low and one for a high supply threshold. It produces the system reset, a one-hot record of the last reset cause, and a flag that warns software that retained data may no longer be valid. It keeps three configuration bits: monitor enable, threshold select, and monitor-as-reset-source select. Only a power-on event clears these bits. Software, monitor and flash-error resets leave them as they were.

The sequencer is a four-state machine. `ST_POR_WAIT` holds reset for a programmable count after power-on. `ST_RUN` is normal operation. `ST_MON_HOLD` holds reset while the selected comparator reports a low supply. `ST_PULSE` holds reset for a fixed count after a software or flash-error reset.

The machine has these transitions:
- `ST_POR_WAIT` goes to `ST_RUN` when the power-on count expires.
- `ST_RUN` goes to `ST_MON_HOLD` on a monitor trip.
- `ST_RUN` goes to `ST_PULSE` on a software request or on a blocked flash operation.
- `ST_MON_HOLD` goes to `ST_RUN` as soon as the supply is good, with no power-on count.
- `ST_PULSE` goes to `ST_RUN` when the pulse count expires.

A flash erase or write strobe is granted only when the monitor is enabled and set to the high threshold. In any other setting the strobe is turned into a flash-error reset.

Top module: `supmon_rst_ctrl`

## Requirements
- R1: While the monitor is enabled (`cfg_o[0]`) and selected as a reset source (`cfg_o[2]`), a low level on the selected comparator asserts `sys_rst_o` 3 clock edges later. The delay is two synchroniser flops plus the state register, and `cause_o` becomes 4'b0010.
- R2: Power-on sets `cfg_o` to 3'b101: enable=1 at bit 0, high threshold=0 at bit 1, source select=1 at bit 2. A write with `cfg_wr_i` loads `cfg_wdata_i` using the same bit positions, but only while `sys_rst_o` is low. Writes during reset are ignored.
- R3: Software, monitor and flash-error resets leave `cfg_o` unchanged.
- R4: A `flash_op_i` strobe seen while `cfg_o[0]` and `cfg_o[1]` are both 1 gives a one-cycle `flash_grant_o` on the next cycle. In any other setting the strobe raises a flash-error reset, with `cause_o` 4'b1000, and no grant.
- R5: A monitor-held reset releases 3 clock edges after the comparator returns high, without the power-on delay.
- R6: With `cfg_o[2]`=0, comparator levels cause no reset.
- R7: `cfg_o[1]`=0 makes the trip use `cmp_lo_i`. `cfg_o[1]`=1 makes it use `cmp_hi_i`.
- R8: `settle_o` is low while the monitor is disabled. It rises `SETTLE_CYC` clock edges after the edge that sets the enable bit. It does not gate tripping, so selecting the source before it rises can reset the system when the comparator is low.
- R9: `cause_o` is one-hot, with bit0=power-on, bit1=monitor, bit2=software and bit3=flash error. It changes only on reset entry. `por_flag_o` is 1 exactly when bit0 or bit1 is set.
- R10: `sys_rst_o` rises with `por_i` without waiting for a clock. It falls `POR_DLY` clock edges after `por_i` is released.
- R11: A `sw_rst_i` request in normal operation holds `sys_rst_o` high for `RST_PULSE` clock edges. `cause_o` becomes 4'b0100.
- R12: When events coincide, a monitor trip wins over a software request, and a software request wins over a flash strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset pulse, active high, asynchronous |
| cmp_lo_i | input | 1 | Low-threshold comparator, 1 = supply above threshold |
| cmp_hi_i | input | 1 | High-threshold comparator, 1 = supply above threshold |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 3 | Configuration write data {select, high, enable} |
| sw_rst_i | input | 1 | Software reset request |
| flash_op_i | input | 1 | Flash erase/write strobe |
| sys_rst_o | output | 1 | System reset, active high |
| flash_grant_o | output | 1 | Flash operation allowed, one-cycle pulse |
| cfg_o | output | 3 | Configuration readback {select, high, enable} |
| settle_o | output | 1 | Comparator settled status |
| cause_o | output | 4 | One-hot cause of the last reset |
| por_flag_o | output | 1 | Retained data may be invalid |

## Verification
The bench builds the block with `POR_DLY`=16, `SETTLE_CYC`=8 and `RST_PULSE`=4. These small values let the bench check the exact release edge of the power-on delay, the software pulse and the settle status within a few dozen cycles. The short settle count also leaves room to select the monitor source while `settle_o` is still low and to watch the early trip this causes.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

    typedef enum logic [1:0] {
        ST_POR_WAIT = 2'd0,
        ST_RUN      = 2'd1,
        ST_MON_HOLD = 2'd2,
        ST_PULSE    = 2'd3
    } st_e;

    typedef struct packed {
        logic sel;
        logic hi;
        logic en;
    } cfg_t;

    localparam cfg_t CFG_POR = '{sel: 1'b1, hi: 1'b0, en: 1'b1};

    localparam int CAUSE_W = 4;
    localparam logic [CAUSE_W-1:0] CAUSE_POR   = 4'b0001;
    localparam logic [CAUSE_W-1:0] CAUSE_MON   = 4'b0010;
    localparam logic [CAUSE_W-1:0] CAUSE_SW    = 4'b0100;
    localparam logic [CAUSE_W-1:0] CAUSE_FLASH = 4'b1000;

endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
    parameter int W = 2
) (
    input  logic         clk_i,
    input  logic         por_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q;
        logic sync_q;

        always_ff @(posedge clk_i or posedge por_i) begin
            if (por_i) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= d_i[b];
                sync_q <= meta_q;
            end
        end

        assign q_o[b] = sync_q;
    end

endmodule

// File: rtl/supmon_cfg.sv
module supmon_cfg
    import supmon_pkg::*;
(
    input  logic clk_i,
    input  logic por_i,
    input  logic wr_i,
    input  cfg_t wdata_i,
    output cfg_t cfg_o
);

    // Only power-on touches these bits; every other reset leaves them alone.
    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            cfg_o <= CFG_POR;
        end else if (wr_i) begin
            cfg_o <= wdata_i;
        end
    end

endmodule

// File: rtl/supmon_settle.sv
module supmon_settle #(
    parameter int SETTLE_CYC = 64
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic en_i,
    output logic settled_o
);

    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam logic [SW-1:0] LIMIT = SW'(SETTLE_CYC);

    logic [SW-1:0] cnt_q;

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            cnt_q <= '0;
        end else if (!en_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign settled_o = (cnt_q == LIMIT);

endmodule

// File: rtl/supmon_rst_ctrl.sv
module supmon_rst_ctrl
    import supmon_pkg::*;
#(
    parameter int POR_DLY    = 1024,
    parameter int SETTLE_CYC = 64,
    parameter int RST_PULSE  = 8
) (
    input  logic       clk_i,
    input  logic       por_i,
    input  logic       cmp_lo_i,
    input  logic       cmp_hi_i,
    input  logic       cfg_wr_i,
    input  logic [2:0] cfg_wdata_i,
    input  logic       sw_rst_i,
    input  logic       flash_op_i,
    output logic       sys_rst_o,
    output logic       flash_grant_o,
    output logic [2:0] cfg_o,
    output logic       settle_o,
    output logic [3:0] cause_o,
    output logic       por_flag_o
);

    localparam int MAXC  = (POR_DLY > RST_PULSE) ? POR_DLY : RST_PULSE;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] POR_LAST   = CNT_W'(POR_DLY - 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(RST_PULSE - 1);

    st_e              state, nxt;
    logic [CNT_W-1:0] cnt_q;
    cfg_t             cfg;
    logic [1:0]       cmp_s;
    logic             good_s;
    logic             trip;
    logic             flash_safe;
    logic             wr_ok;
    logic             grant_q;
    logic [3:0]       cause_q;

    supmon_sync #(.W(2)) u_sync (
        .clk_i (clk_i),
        .por_i (por_i),
        .d_i   ({cmp_hi_i, cmp_lo_i}),
        .q_o   (cmp_s)
    );

    supmon_cfg u_cfg (
        .clk_i   (clk_i),
        .por_i   (por_i),
        .wr_i    (cfg_wr_i && wr_ok),
        .wdata_i (cfg_t'(cfg_wdata_i)),
        .cfg_o   (cfg)
    );

    supmon_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk_i     (clk_i),
        .por_i     (por_i),
        .en_i      (cfg.en),
        .settled_o (settle_o)
    );

    // Threshold select picks which synchronised comparator is trusted.
    assign good_s     = cfg.hi ? cmp_s[1] : cmp_s[0];
    assign trip       = cfg.en && cfg.sel && !good_s;
    assign flash_safe = cfg.en && cfg.hi;
    assign wr_ok      = (state == ST_RUN) && (nxt == ST_RUN);

    // Next-state logic.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_POR_WAIT: begin
                if (cnt_q == POR_LAST) nxt = ST_RUN;
            end
            ST_RUN: begin
                if (trip)                          nxt = ST_MON_HOLD;
                else if (sw_rst_i)                 nxt = ST_PULSE;
                else if (flash_op_i && !flash_safe) nxt = ST_PULSE;
            end
            ST_MON_HOLD: begin
                if (!trip) nxt = ST_RUN;
            end
            ST_PULSE: begin
                if (cnt_q == PULSE_LAST) nxt = ST_RUN;
            end
            default: nxt = ST_POR_WAIT;
        endcase
    end

    // State register and its dwell counter.
    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            state <= ST_POR_WAIT;
            cnt_q <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) begin
                cnt_q <= '0;
            end else if (state == ST_POR_WAIT || state == ST_PULSE) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Registered outputs: reset cause and flash grant.
    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            cause_q <= CAUSE_POR;
            grant_q <= 1'b0;
        end else begin
            grant_q <= (state == ST_RUN) && (nxt == ST_RUN) && flash_op_i && flash_safe;
            if (state == ST_RUN && nxt != ST_RUN) begin
                if (nxt == ST_MON_HOLD) cause_q <= CAUSE_MON;
                else if (sw_rst_i)      cause_q <= CAUSE_SW;
                else                    cause_q <= CAUSE_FLASH;
            end
        end
    end

    // Asynchronous assertion from power-on, synchronous release from the state register.
    assign sys_rst_o     = por_i || (state != ST_RUN);
    assign flash_grant_o = grant_q;
    assign cfg_o         = cfg;
    assign cause_o       = cause_q;
    assign por_flag_o    = cause_q[0] || cause_q[1];

endmodule

module supmon_rst_ctrl_chk
    import supmon_pkg::*;
(
    input logic       clk_i,
    input logic       por_i,
    input logic       sw_rst_i,
    input logic       flash_op_i,
    input logic       cfg_wr_i,
    input logic       sys_rst_o,
    input logic       flash_grant_o,
    input logic [2:0] cfg_o,
    input logic       settle_o,
    input logic [3:0] cause_o,
    input st_e        state,
    input logic       good_s
);

    p_trip_r1: assert property (@(posedge clk_i) disable iff (por_i)
        (state == ST_RUN && cfg_o[0] && cfg_o[2] && !good_s) |=> (sys_rst_o && cause_o == 4'b0010));

    p_cfg_hold_r3: assert property (@(posedge clk_i) disable iff (por_i)
        !cfg_wr_i |=> $stable(cfg_o));

    p_flash_err_r4: assert property (@(posedge clk_i) disable iff (por_i)
        (state == ST_RUN && flash_op_i && !(cfg_o[0] && cfg_o[1]) && !sw_rst_i
         && !(cfg_o[0] && cfg_o[2] && !good_s)) |=> (sys_rst_o && cause_o == 4'b1000 && !flash_grant_o));

    p_grant_safe_r4: assert property (@(posedge clk_i) disable iff (por_i)
        flash_grant_o |-> $past(cfg_o[0] && cfg_o[1] && flash_op_i));

    p_mon_fast_r5: assert property (@(posedge clk_i) disable iff (por_i)
        (state == ST_MON_HOLD && good_s) |=> !sys_rst_o);

    p_settle_off_r8: assert property (@(posedge clk_i) disable iff (por_i)
        !cfg_o[0] |=> !settle_o);

    p_cause_onehot_r9: assert property (@(posedge clk_i) disable iff (por_i)
        $countones(cause_o) == 1);

    p_sw_rst_r11: assert property (@(posedge clk_i) disable iff (por_i)
        (state == ST_RUN && sw_rst_i) |=> sys_rst_o);

endmodule

bind supmon_rst_ctrl supmon_rst_ctrl_chk u_chk (
    .clk_i         (clk_i),
    .por_i         (por_i),
    .sw_rst_i      (sw_rst_i),
    .flash_op_i    (flash_op_i),
    .cfg_wr_i      (cfg_wr_i),
    .sys_rst_o     (sys_rst_o),
    .flash_grant_o (flash_grant_o),
    .cfg_o         (cfg_o),
    .settle_o      (settle_o),
    .cause_o       (cause_o),
    .state         (state),
    .good_s        (good_s)
);

// File: tb/supmon_rst_ctrl_test.sv
module supmon_rst_ctrl_test;

    localparam int CLK_P  = 10;
    localparam int P_POR  = 16;
    localparam int P_SET  = 8;
    localparam int P_PUL  = 4;

    // {cfg[2:0], expect grant, expect error reset}
    localparam logic [4:0] FVEC [4] = '{
        5'b011_1_0,
        5'b001_0_1,
        5'b010_0_1,
        5'b000_0_1
    };

    logic       clk = 1'b0;
    logic       por_i = 1'b1;
    logic       cmp_lo_i = 1'b1;
    logic       cmp_hi_i = 1'b1;
    logic       cfg_wr_i = 1'b0;
    logic [2:0] cfg_wdata_i = '0;
    logic       sw_rst_i = 1'b0;
    logic       flash_op_i = 1'b0;
    logic       sys_rst_o;
    logic       flash_grant_o;
    logic [2:0] cfg_o;
    logic       settle_o;
    logic [3:0] cause_o;
    logic       por_flag_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    supmon_rst_ctrl #(.POR_DLY(P_POR), .SETTLE_CYC(P_SET), .RST_PULSE(P_PUL)) uut (
        .clk_i (clk), .por_i (por_i), .cmp_lo_i (cmp_lo_i), .cmp_hi_i (cmp_hi_i),
        .cfg_wr_i (cfg_wr_i), .cfg_wdata_i (cfg_wdata_i), .sw_rst_i (sw_rst_i),
        .flash_op_i (flash_op_i), .sys_rst_o (sys_rst_o), .flash_grant_o (flash_grant_o),
        .cfg_o (cfg_o), .settle_o (settle_o), .cause_o (cause_o), .por_flag_o (por_flag_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] v);
        cfg_wr_i = 1'b1;
        cfg_wdata_i = v;
        cyc(1);
        cfg_wr_i = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1;
        chk("R10", "reset asserted with por", 32'(sys_rst_o), 1);
        cyc(3);
        por_i = 1'b0;
        cyc(P_POR - 1);
        chk("R10", "still in reset before delay end", 32'(sys_rst_o), 1);
        cyc(1);
        chk("R10", "released after delay", 32'(sys_rst_o), 0);
        chk("R9", "cause after power-on", 32'(cause_o), 32'h1);
        chk("R9", "data-invalid flag after power-on", 32'(por_flag_o), 1);
        chk("R2", "power-on config", 32'(cfg_o), 32'h5);
        chk("R8", "settled after power-on", 32'(settle_o), 1);

        // Flash strobe against each monitor setting (R4, R3).
        for (int i = 0; i < 4; i++) begin
            wr(FVEC[i][4:2]);
            flash_op_i = 1'b1;
            cyc(1);
            flash_op_i = 1'b0;
            chk("R4", "grant", 32'(flash_grant_o), 32'(FVEC[i][1]));
            chk("R4", "error reset", 32'(sys_rst_o), 32'(FVEC[i][0]));
            if (FVEC[i][0]) begin
                chk("R4", "cause flash error", 32'(cause_o), 32'h8);
                chk("R9", "flag clear after flash error", 32'(por_flag_o), 0);
                cyc(P_PUL);
                chk("R4", "error reset ends", 32'(sys_rst_o), 0);
                chk("R3", "config survives flash error", 32'(cfg_o), 32'(FVEC[i][4:2]));
            end else begin
                cyc(1);
                chk("R4", "grant is one cycle", 32'(flash_grant_o), 0);
            end
        end

        // Software reset, write ignored during it (R11, R2, R3).
        wr(3'b011);
        sw_rst_i = 1'b1;
        cyc(1);
        sw_rst_i = 1'b0;
        chk("R11", "software reset asserted", 32'(sys_rst_o), 1);
        chk("R11", "cause software", 32'(cause_o), 32'h4);
        wr(3'b000);
        cyc(P_PUL - 2);
        chk("R11", "still in software reset", 32'(sys_rst_o), 1);
        cyc(1);
        chk("R11", "software reset ends", 32'(sys_rst_o), 0);
        chk("R3", "config survives software reset", 32'(cfg_o), 32'h3);
        chk("R2", "write during reset ignored", 32'(cfg_o), 32'h3);

        // Settle timing (R8).
        wr(3'b000);
        cyc(1);
        chk("R8", "settle low when disabled", 32'(settle_o), 0);
        wr(3'b001);
        cyc(P_SET - 1);
        chk("R8", "settle not yet high", 32'(settle_o), 0);
        cyc(1);
        chk("R8", "settle high on time", 32'(settle_o), 1);

        // Source not selected, then selected before settling (R6, R8, R1, R5).
        wr(3'b000);
        cyc(1);
        cmp_lo_i = 1'b0;
        wr(3'b001);
        cyc(4);
        chk("R6", "no reset without source select", 32'(sys_rst_o), 0);
        wr(3'b101);
        chk("R8", "selected while unsettled", 32'(settle_o), 0);
        chk("R1", "no reset yet", 32'(sys_rst_o), 0);
        cyc(1);
        chk("R8", "early select trips reset", 32'(sys_rst_o), 1);
        chk("R1", "cause monitor", 32'(cause_o), 32'h2);
        chk("R9", "flag set after monitor reset", 32'(por_flag_o), 1);
        cmp_lo_i = 1'b1;
        cyc(2);
        chk("R5", "held until sync catches up", 32'(sys_rst_o), 1);
        cyc(1);
        chk("R5", "fast release after monitor reset", 32'(sys_rst_o), 0);
        chk("R3", "config survives monitor reset", 32'(cfg_o), 32'h5);

        // Threshold select (R7, R1).
        wr(3'b111);
        cmp_hi_i = 1'b0;
        cyc(2);
        chk("R1", "trip latency not yet", 32'(sys_rst_o), 0);
        cyc(1);
        chk("R7", "high comparator used", 32'(sys_rst_o), 1);
        cmp_hi_i = 1'b1;
        cyc(3);
        chk("R5", "release high threshold", 32'(sys_rst_o), 0);
        wr(3'b101);
        cmp_hi_i = 1'b0;
        cyc(4);
        chk("R7", "high comparator ignored on low setting", 32'(sys_rst_o), 0);
        cmp_hi_i = 1'b1;

        // Priority (R12).
        cmp_lo_i = 1'b0;
        cyc(2);
        sw_rst_i = 1'b1;
        flash_op_i = 1'b1;
        cyc(1);
        sw_rst_i = 1'b0;
        flash_op_i = 1'b0;
        chk("R12", "monitor beats software", 32'(cause_o), 32'h2);
        cmp_lo_i = 1'b1;
        cyc(3);
        chk("R12", "released", 32'(sys_rst_o), 0);
        sw_rst_i = 1'b1;
        flash_op_i = 1'b1;
        cyc(1);
        sw_rst_i = 1'b0;
        flash_op_i = 1'b0;
        chk("R12", "software beats flash", 32'(cause_o), 32'h4);
        chk("R12", "no grant", 32'(flash_grant_o), 0);
        cyc(P_PUL);
        chk("R12", "pulse ends", 32'(sys_rst_o), 0);

        // Power-on restores config (R2).
        wr(3'b010);
        por_i = 1'b1;
        #1;
        chk("R10", "async assert", 32'(sys_rst_o), 1);
        chk("R2", "power-on restores config", 32'(cfg_o), 32'h5);
        cyc(2);
        por_i = 1'b0;
        cyc(P_POR);
        chk("R10", "second release", 32'(sys_rst_o), 0);
        chk("R9", "cause power-on again", 32'(cause_o), 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule